// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard-control logic for an in-order integer pipeline of five stages: fetch, decode with register read, execute, memory access and write-back. It looks at the source register numbers of the instruction in decode, together with the destination, write and load flags of the instructions in execute, memory and write-back. It also looks at a flag that marks a memory-stage instruction holding the single shared memory port. From these inputs it produces a bypass select for each ALU operand, a hold for fetch and decode, and a kill that turns the next execute slot into a no-op.

Registers are read only in decode and written only in write-back, so only read-after-write dependences need handling. The block registers the decode source numbers into an execute-side tracker. Each select is computed for the instruction that is currently in execute. The register file is assumed to write in the first half of a cycle and read in the second half, so decode never needs a bypass. A load whose result is wanted at once by the next instruction costs one hold cycle. A data access in memory stage also costs one hold cycle, because it takes the port away from fetch.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: An operand select reads 00 (register file) when no qualifying writer in memory or write-back stage targets that operand's source register, including when the writer's write flag is low.
- R2: An operand select reads 01 when the memory-stage instruction has its write flag set, is not a load, and its destination equals the execute instruction's source register for that operand.
- R3: An operand select reads 10 when the write-back instruction has its write flag set and its destination matches, and the memory stage does not qualify under R2.
- R4: When both memory and write-back stages match the same source, the select is 01: the younger result wins.
- R5: Operand A follows the first decode source and operand B follows the second, each chosen without regard to the other.
- R6: Register number 0 never causes a non-zero select or a hold, whether it is a source or a destination.
- R7: A load in memory stage is never a 01 source; its matching operand falls through to the write-back check.
- R8: When the execute instruction is a load with its write flag set and a non-zero destination equal to either decode source, hold and kill are both high in that same cycle.
- R9: In the cycle after a hold, the execute slot is empty, so both selects read 00 whatever the stage destinations are.
- R10: When the memory-stage data-access flag is high, hold and kill are both high in that cycle.
- R11: A load-use conflict and a port conflict in the same cycle give one hold with kill high, and hold and kill are always equal.
- R12: While reset is high, hold and kill are low. In the first cycle after reset, both selects read 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_src_a | input | 5 | First source register of the decode instruction |
| dec_src_b | input | 5 | Second source register of the decode instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_ld | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_ld | input | 1 | Memory-stage instruction is a load |
| mem_dacc | input | 1 | Memory-stage instruction uses the shared memory port |
| wb_dst | input | 5 | Destination register of the write-back instruction |
| wb_wr | input | 1 | Write-back instruction writes a register |
| fwd_sel_a | output | 2 | Bypass select for ALU operand A |
| fwd_sel_b | output | 2 | Bypass select for ALU operand B |
| hold_fd | output | 1 | Hold fetch and decode in place |
| kill_ex | output | 1 | Insert a no-op into execute |

## Verification
The hardest case to reach is the empty execute slot that follows a hold. In that cycle an older source number is still present in the tracker, and a live writer in memory or write-back stage may match it, so a design that drops the valid bit will forward a value it should not. The stimulus first raises a hold by a load-use conflict, and later by a port conflict. In the very next cycle it places a writer whose destination equals the source of the instruction that was held, and expects both selects to read 00. The combined conflict and the load sitting in memory stage are also driven on purpose.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned FWD_W     = 2;
    localparam int unsigned NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [FWD_W-1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        reg_idx_t dst;
        logic     wr;
        logic     ld;
    } wr_info_t;

    function automatic logic writes_reg(input wr_info_t w, input reg_idx_t r);
        return w.wr && (w.dst != '0) && (w.dst == r);
    endfunction

endpackage

// File: rtl/hzd_src_track.sv
module hzd_src_track
    import hzd_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold,
    input  reg_idx_t [NSRC-1:0]  dec_src,
    output logic                 ex_vld,
    output reg_idx_t [NSRC-1:0]  ex_src
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_vld <= 1'b0;
        end else begin
            ex_vld <= !hold;
        end
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                ex_src[i] <= '0;
            end else if (!hold) begin
                ex_src[i] <= dec_src[i];
            end
        end
    end

endmodule

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
    import hzd_pkg::*;
(
    input  logic     src_vld,
    input  reg_idx_t src,
    input  wr_info_t mem_info,
    input  wr_info_t wb_info,
    output fwd_sel_e sel
);

    always_comb begin
        sel = FWD_RF;
        if (src_vld) begin
            if (writes_reg(mem_info, src) && !mem_info.ld) begin
                sel = FWD_MEM;
            end else if (writes_reg(wb_info, src)) begin
                sel = FWD_WB;
            end
        end
    end

endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det
    import hzd_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  logic                rst,
    input  reg_idx_t [NSRC-1:0] dec_src,
    input  wr_info_t            ex_info,
    input  logic                mem_dacc,
    output logic                hold,
    output logic                kill
);

    logic [NSRC-1:0] src_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign src_hit[i] = ex_info.ld && writes_reg(ex_info, dec_src[i]);
    end

    logic load_use;
    logic port_busy;

    assign load_use  = |src_hit;
    assign port_busy = mem_dacc;
    assign hold      = !rst && (load_use || port_busy);
    assign kill      = hold;

endmodule

// File: rtl/hazard_fwd_ctrl.sv
module hazard_fwd_ctrl
    import hzd_pkg::*;
#(
    parameter int unsigned RW = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [RW-1:0] dec_src_a,
    input  logic [RW-1:0] dec_src_b,
    input  logic [RW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_ld,
    input  logic [RW-1:0] mem_dst,
    input  logic          mem_wr,
    input  logic          mem_ld,
    input  logic          mem_dacc,
    input  logic [RW-1:0] wb_dst,
    input  logic          wb_wr,
    output logic [1:0]    fwd_sel_a,
    output logic [1:0]    fwd_sel_b,
    output logic          hold_fd,
    output logic          kill_ex
);

    reg_idx_t [NUM_SRC-1:0] dec_src;
    reg_idx_t [NUM_SRC-1:0] ex_src;
    fwd_sel_e [NUM_SRC-1:0] sel;
    wr_info_t               ex_info, mem_info, wb_info;
    logic                   ex_vld;
    logic                   hold_w, kill_w;

    assign dec_src[0] = dec_src_a;
    assign dec_src[1] = dec_src_b;
    assign ex_info    = '{dst: ex_dst,  wr: ex_wr,  ld: ex_ld};
    assign mem_info   = '{dst: mem_dst, wr: mem_wr, ld: mem_ld};
    assign wb_info    = '{dst: wb_dst,  wr: wb_wr,  ld: 1'b0};

    hzd_stall_det #(.NSRC(NUM_SRC)) u_stall (
        .rst      (rst),
        .dec_src  (dec_src),
        .ex_info  (ex_info),
        .mem_dacc (mem_dacc),
        .hold     (hold_w),
        .kill     (kill_w)
    );

    hzd_src_track #(.NSRC(NUM_SRC)) u_track (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold_w),
        .dec_src (dec_src),
        .ex_vld  (ex_vld),
        .ex_src  (ex_src)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_fwd
        hzd_fwd_sel u_sel (
            .src_vld  (ex_vld),
            .src      (ex_src[i]),
            .mem_info (mem_info),
            .wb_info  (wb_info),
            .sel      (sel[i])
        );
    end

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];
    assign hold_fd   = hold_w;
    assign kill_ex   = kill_w;

endmodule

// File: rtl/hazard_fwd_ctrl_chk.sv
module hazard_fwd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] dec_src_a,
    input logic [4:0] dec_src_b,
    input logic [4:0] ex_dst,
    input logic       ex_wr,
    input logic       ex_ld,
    input logic [4:0] mem_dst,
    input logic       mem_wr,
    input logic       mem_ld,
    input logic       mem_dacc,
    input logic [4:0] wb_dst,
    input logic       wb_wr,
    input logic [1:0] fwd_sel_a,
    input logic [1:0] fwd_sel_b,
    input logic       hold_fd,
    input logic       kill_ex
);

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_a != 2'b11 && fwd_sel_b != 2'b11); // R1

    AST_MEM_SRC_OK: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_a == 2'b01 |-> mem_wr && !mem_ld && mem_dst != 5'd0); // R7

    AST_WB_SRC_OK: assert property (@(posedge clk) disable iff (rst)
        fwd_sel_b == 2'b10 |-> wb_wr && wb_dst != 5'd0); // R6

    AST_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_dacc |-> hold_fd && kill_ex); // R10

    AST_LOAD_USE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ex_ld && ex_wr && ex_dst != 5'd0 && dec_src_b == ex_dst) |-> hold_fd); // R8

    AST_BUBBLE_NO_FWD: assert property (@(posedge clk) disable iff (rst)
        hold_fd |=> fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !hold_fd && !kill_ex); // R12

endmodule

bind hazard_fwd_ctrl hazard_fwd_ctrl_chk u_chk (.*);

// File: tb/hazard_fwd_ctrl_bench.sv
`timescale 1ns/100ps
module hazard_fwd_ctrl_bench;

    typedef struct {
        logic       rst;
        logic [4:0] a, b, exd;
        logic       exw, exl;
        logic [4:0] md;
        logic       mw, ml, mda;
        logic [4:0] wd;
        logic       ww;
    } stim_t;

    typedef struct {
        logic [1:0] fa, fb;
        logic       st, kl;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
    logic       ex_wr, ex_ld, mem_wr, mem_ld, mem_dacc, wb_wr;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic       hold_fd, kill_ex;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic       m_vld = 1'b0;
    logic [4:0] m_a = '0, m_b = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    hazard_fwd_ctrl u_hazard_fwd_ctrl (.*);

    function automatic stim_t mk(int r, int a, int b, int exd, int exw, int exl,
                                 int md, int mw, int ml, int mda, int wd, int ww);
        stim_t s;
        s.rst = 1'(r);   s.a = 5'(a);   s.b = 5'(b);
        s.exd = 5'(exd); s.exw = 1'(exw); s.exl = 1'(exl);
        s.md = 5'(md);   s.mw = 1'(mw); s.ml = 1'(ml); s.mda = 1'(mda);
        s.wd = 5'(wd);   s.ww = 1'(ww);
        return s;
    endfunction

    function automatic logic [1:0] ref_sel(stim_t s, logic v, logic [4:0] src);
        if (!v) return 2'b00;
        if (s.mw && s.md != 0 && s.md == src && !s.ml) return 2'b01;
        if (s.ww && s.wd != 0 && s.wd == src) return 2'b10;
        return 2'b00;
    endfunction

    task automatic apply(input stim_t s, input string tag);
        exp_t e;
        @(negedge clk);
        rst = s.rst; dec_src_a = s.a; dec_src_b = s.b;
        ex_dst = s.exd; ex_wr = s.exw; ex_ld = s.exl;
        mem_dst = s.md; mem_wr = s.mw; mem_ld = s.ml; mem_dacc = s.mda;
        wb_dst = s.wd; wb_wr = s.ww;
        e.fa = ref_sel(s, m_vld, m_a);
        e.fb = ref_sel(s, m_vld, m_b);
        e.st = !s.rst && (s.mda || (s.exl && s.exw && s.exd != 0 &&
                                    (s.exd == s.a || s.exd == s.b)));
        e.kl = e.st;
        e.tag = tag;
        q.push_back(e);
        if (s.rst || e.st) m_vld = 1'b0;
        else begin m_vld = 1'b1; m_a = s.a; m_b = s.b; end
    endtask

    task automatic cmp(input string what, input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #1.5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                cmp("fwd_sel_a", e.tag, fwd_sel_a, e.fa);
                cmp("fwd_sel_b", e.tag, fwd_sel_b, e.fb);
                cmp("hold_fd",   e.tag, {1'b0, hold_fd}, {1'b0, e.st});
                cmp("kill_ex",   e.tag, {1'b0, kill_ex}, {1'b0, e.kl});
            end
        end
    end

    initial begin : watchdog
        #50000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        apply(mk(1, 1,2, 1,1,1, 1,1,0,1, 2,1), "R12");
        apply(mk(1, 1,2, 2,1,1, 1,1,0,1, 2,1), "R12");
        apply(mk(0, 1,2, 0,0,0, 1,1,0,0, 2,1), "R12");
        apply(mk(0, 3,4, 0,0,0, 1,1,0,0, 0,0), "R2");
        apply(mk(0, 5,6, 0,0,0, 9,1,0,0, 3,1), "R3 R1");
        apply(mk(0, 7,8, 0,0,0, 6,1,0,0, 5,1), "R5");
        apply(mk(0, 9,9, 0,0,0, 7,1,0,0, 7,1), "R4");
        apply(mk(0, 0,0, 0,0,0, 9,1,1,0, 9,1), "R7");
        apply(mk(0, 1,0, 0,0,0, 0,1,0,0, 0,1), "R6");
        apply(mk(0, 5,3, 3,1,1, 1,0,0,0, 0,0), "R1 R8");
        apply(mk(0, 5,3, 0,0,0, 1,1,0,0, 1,1), "R9");
        apply(mk(0, 2,4, 0,0,0, 0,0,0,0, 3,1), "R3");
        apply(mk(0, 0,0, 0,1,1, 0,0,0,0, 0,0), "R6");
        apply(mk(0, 1,2, 7,1,1, 0,0,0,0, 0,0), "R8");
        apply(mk(0, 1,2, 2,0,1, 0,0,0,0, 0,0), "R8");
        apply(mk(0, 1,2, 0,0,0, 0,0,0,1, 0,0), "R10");
        apply(mk(0, 1,2, 0,0,0, 1,1,0,0, 2,1), "R9 R10");
        apply(mk(0, 4,6, 4,1,1, 1,1,0,1, 2,1), "R11");
        apply(mk(0, 4,6, 0,0,0, 4,1,0,0, 6,1), "R11 R9");
        apply(mk(0, 3,3, 0,0,0, 4,1,0,0, 6,0), "R2 R1");
        apply(mk(1, 3,3, 3,1,1, 3,1,0,1, 3,1), "R12");
        apply(mk(0, 3,3, 0,0,0, 3,1,0,0, 3,1), "R12");
        apply(mk(0, 0,0, 0,0,0, 3,1,0,0, 0,0), "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule